// File: doc/BRIEF.md
# Neighbour-Exchange Key Sorting Array

This block sorts a set of unsigned keys held in a row of cells. Each cell stores one key and compares it only with the cells directly to its left and right. A parallel load writes every cell in one cycle. A start pulse then runs a fixed number of compare-exchange steps. The steps alternate between two sets of neighbour pairs. In each pair, the smaller key ends up in the lower-indexed cell.

After the last step the block raises a one-cycle completion pulse. The sorted keys then sit on a flat output bus, with cell 0 holding the smallest key. They stay there unchanged until the next load. The number of cells and the key width are parameters. The run length depends only on the cell count and never on the data.

Top module: `nbr_xchg_sorter`

## Requirements
- R1: After reset, all cells read zero and both `done_o` and `busy_o` are low.
- R2: A cycle with `load_i` high copies `load_keys_i` into all cells. Cell i takes bits [i*KEY_W +: KEY_W]. The new keys appear on `keys_o` in the next cycle, with `busy_o` and `done_o` low.
- R3: When `done_o` is high, `keys_o` is in ascending order from cell 0 upward. It is a permutation of the keys last loaded.
- R4: A start sampled while idle and without load makes `busy_o` high for exactly CELLS cycles. `done_o` is high for the single cycle that follows.
- R5: Steps alternate, beginning with step 0. Even steps act on pairs (0,1), (2,3) and so on. Odd steps act on pairs (1,2), (3,4) and so on. A cell with no partner in a step keeps its key. In each pair the smaller key goes to the lower index, and equal keys stay where they are.
- R6: A load during a run aborts the run. The cells take the new keys and the block goes idle. If load and start arrive together, load wins and no run begins.
- R7: A start pulse while busy is ignored, and the run still ends exactly CELLS cycles after its own start.
- R8: While idle and not loading, `keys_o` does not change. This includes the cycles after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write all cells from `load_keys_i` |
| load_keys_i | input | CELLS*KEY_W | Keys to load; cell i at [i*KEY_W +: KEY_W] |
| start_i | input | 1 | Begin a sorting run |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the final step |
| keys_o | output | CELLS*KEY_W | Current cell contents, same packing as the load bus |

## Verification
The bench sorts every possible input of a small odd-sized array. This covers sorted, reverse-sorted, all-equal and duplicate-heavy inputs. A run that is one step short leaves some reverse inputs unsorted. A swap on equal keys or a wrong compare direction shows up as a mis-ordered output.

The odd cell count leaves an unpaired end cell on every step. The bench checks the contents after step 0 and after step 1 against its own model of one phase. A block that starts on the wrong phase, or that disturbs the unpaired cell, fails there. Further tests load during a run, load and start in the same cycle, and start while busy. A controller that keeps running, or that restarts its step count, would miss the expected done cycle or the expected contents.

// File: rtl/nbr_xchg_pkg.sv
package nbr_xchg_pkg;
   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } xchg_phase_e;
endpackage

// File: rtl/nbr_xchg_cmpx.sv
module nbr_xchg_cmpx #(
   parameter int KEY_W = 16
) (
   input  logic [KEY_W-1:0] left_i,
   input  logic [KEY_W-1:0] right_i,
   output logic [KEY_W-1:0] lo_o,
   output logic [KEY_W-1:0] hi_o
);
   // swap only on strict inversion, equal keys keep their cells
   logic inverted;
   assign inverted = right_i < left_i;
   assign lo_o = inverted ? right_i : left_i;
   assign hi_o = inverted ? left_i  : right_i;
endmodule

// File: rtl/nbr_xchg_ctrl.sv
module nbr_xchg_ctrl
   import nbr_xchg_pkg::*;
#(
   parameter int CELLS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic        start_i,
   output logic        step_en_o,
   output xchg_phase_e phase_o,
   output logic        busy_o,
   output logic        done_o
);
   localparam int STEP_W = (CELLS > 2) ? $clog2(CELLS) : 1;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CELLS - 1);

   logic [STEP_W-1:0] step_q;
   logic              busy_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (load_i) begin
         step_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (busy_q) begin
         if (step_q == LAST_STEP) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            step_q <= step_q + 1'b1;
            done_q <= 1'b0;
         end
      end else if (start_i) begin
         step_q <= '0;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
      end
   end

   assign step_en_o = busy_q && !load_i;
   assign phase_o   = xchg_phase_e'(step_q[0]);
   assign busy_o    = busy_q;
   assign done_o    = done_q;
endmodule

// File: rtl/nbr_xchg_array.sv
module nbr_xchg_array
   import nbr_xchg_pkg::*;
#(
   parameter int CELLS = 8,
   parameter int KEY_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [CELLS*KEY_W-1:0] load_keys_i,
   input  logic                   step_en_i,
   input  xchg_phase_e            phase_i,
   output logic [CELLS*KEY_W-1:0] keys_o
);
   localparam int PAIRS = CELLS - 1;

   logic [KEY_W-1:0] cell_q  [CELLS];
   logic [KEY_W-1:0] pair_lo [PAIRS];
   logic [KEY_W-1:0] pair_hi [PAIRS];

   for (genvar j = 0; j < PAIRS; j++) begin : g_pair
      nbr_xchg_cmpx #(.KEY_W(KEY_W)) u_cmpx (
         .left_i (cell_q[j]),
         .right_i(cell_q[j+1]),
         .lo_o   (pair_lo[j]),
         .hi_o   (pair_hi[j])
      );
   end

   for (genvar i = 0; i < CELLS; i++) begin : g_cell
      logic [KEY_W-1:0] from_right;
      logic [KEY_W-1:0] from_left;
      logic             right_act;
      logic             left_act;
      logic [KEY_W-1:0] nxt;

      if (i < CELLS - 1) begin : g_has_right
         assign from_right = pair_lo[i];
         assign right_act  = (phase_i == xchg_phase_e'(i % 2));
      end else begin : g_no_right
         assign from_right = '0;
         assign right_act  = 1'b0;
      end

      if (i > 0) begin : g_has_left
         assign from_left = pair_hi[i-1];
         assign left_act  = (phase_i == xchg_phase_e'((i - 1) % 2));
      end else begin : g_no_left
         assign from_left = '0;
         assign left_act  = 1'b0;
      end

      always_comb begin
         nxt = cell_q[i];
         if (right_act)     nxt = from_right;
         else if (left_act) nxt = from_left;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         cell_q[i] <= '0;
         else if (load_i)    cell_q[i] <= load_keys_i[i*KEY_W +: KEY_W];
         else if (step_en_i) cell_q[i] <= nxt;
      end

      assign keys_o[i*KEY_W +: KEY_W] = cell_q[i];
   end
endmodule

// File: rtl/nbr_xchg_sorter.sv
module nbr_xchg_sorter
   import nbr_xchg_pkg::*;
#(
   parameter int CELLS = 8,
   parameter int KEY_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [CELLS*KEY_W-1:0] load_keys_i,
   input  logic                   start_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [CELLS*KEY_W-1:0] keys_o
);
   if (CELLS < 2) begin : g_bad_cells
      $error("nbr_xchg_sorter: CELLS must be at least 2");
   end
   if (KEY_W < 1) begin : g_bad_width
      $error("nbr_xchg_sorter: KEY_W must be at least 1");
   end

   logic        step_en;
   xchg_phase_e phase;

   nbr_xchg_ctrl #(.CELLS(CELLS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .start_i  (start_i),
      .step_en_o(step_en),
      .phase_o  (phase),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

   nbr_xchg_array #(.CELLS(CELLS), .KEY_W(KEY_W)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_keys_i(load_keys_i),
      .step_en_i  (step_en),
      .phase_i    (phase),
      .keys_o     (keys_o)
   );
endmodule

// File: rtl/nbr_xchg_sorter_chk.sv
module nbr_xchg_sorter_chk #(
   parameter int CELLS = 8,
   parameter int KEY_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   load_i,
   input logic [CELLS*KEY_W-1:0] load_keys_i,
   input logic                   start_i,
   input logic                   busy_o,
   input logic                   done_o,
   input logic [CELLS*KEY_W-1:0] keys_o
);
   localparam int CNT_W = $clog2(CELLS + 1) + 1;

   logic [CNT_W-1:0] busy_cnt;
   logic             ascending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (load_i) busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   always_comb begin
      ascending = 1'b1;
      for (int i = 0; i < CELLS - 1; i++) begin
         if (keys_o[i*KEY_W +: KEY_W] > keys_o[(i+1)*KEY_W +: KEY_W]) ascending = 1'b0;
      end
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (keys_o == $past(load_keys_i)) && !busy_o && !done_o);

   // R3
   sorted_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ascending);

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cnt == CNT_W'(CELLS)));

   // R4
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !load_i) |=> busy_o);

   // R6
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && start_i) |=> !busy_o);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !load_i) |=> $stable(keys_o));
endmodule

bind nbr_xchg_sorter nbr_xchg_sorter_chk #(.CELLS(CELLS), .KEY_W(KEY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .load_keys_i(load_keys_i),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .keys_o     (keys_o)
);

// File: tb/tb_nbr_xchg_sorter.sv
module tb_nbr_xchg_sorter;
   localparam int CELLS = 5;
   localparam int KEY_W = 2;
   localparam int BUS_W = CELLS * KEY_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_i = 1'b0;
   logic [BUS_W-1:0] load_keys_i = '0;
   logic             start_i = 1'b0;
   logic             busy_o;
   logic             done_o;
   logic [BUS_W-1:0] keys_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   nbr_xchg_sorter #(.CELLS(CELLS), .KEY_W(KEY_W)) dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_keys_i(load_keys_i),
      .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .keys_o(keys_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [BUS_W-1:0] ref_sort(input logic [BUS_W-1:0] v);
      logic [KEY_W-1:0] a [CELLS];
      logic [KEY_W-1:0] t;
      logic [BUS_W-1:0] r;
      for (int i = 0; i < CELLS; i++) a[i] = v[i*KEY_W +: KEY_W];
      for (int i = 1; i < CELLS; i++)
         for (int j = i; j > 0; j--)
            if (a[j] < a[j-1]) begin t = a[j]; a[j] = a[j-1]; a[j-1] = t; end
      for (int i = 0; i < CELLS; i++) r[i*KEY_W +: KEY_W] = a[i];
      return r;
   endfunction

   function automatic logic [BUS_W-1:0] ref_phase(input logic [BUS_W-1:0] v, input int ph);
      logic [BUS_W-1:0] r = v;
      for (int j = ph; j + 1 < CELLS; j += 2) begin
         if (v[(j+1)*KEY_W +: KEY_W] < v[j*KEY_W +: KEY_W]) begin
            r[j*KEY_W +: KEY_W]     = v[(j+1)*KEY_W +: KEY_W];
            r[(j+1)*KEY_W +: KEY_W] = v[j*KEY_W +: KEY_W];
         end
      end
      return r;
   endfunction

   // load at one edge, start at the next; returns at the negedge after start is sampled
   task automatic load_and_start(input logic [BUS_W-1:0] v);
      @(negedge clk); load_i = 1'b1; load_keys_i = v;
      @(negedge clk); load_i = 1'b0; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic full_sort(input logic [BUS_W-1:0] v, input string tag);
      logic [BUS_W-1:0] exp = ref_sort(v);
      load_and_start(v);
      for (int s = 0; s < CELLS; s++) begin
         if (done_o) chk(1'b0, "R4 early done", done_o, 0);
         @(negedge clk);
      end
      chk(done_o === 1'b1, "R4 done timing", done_o, 1);
      chk(keys_o === exp, tag, keys_o, exp);
      @(negedge clk);
      chk(done_o === 1'b0 && keys_o === exp, "R8 hold after done", keys_o, exp);
   endtask

   initial begin
      logic [BUS_W-1:0] v, a, b, exp;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(keys_o === '0 && !done_o && !busy_o, "R1 reset", {busy_o, done_o, keys_o}, 0);
      rst_n = 1'b1;

      // R2 load visible next cycle
      @(negedge clk); load_i = 1'b1; load_keys_i = 10'h2D3;
      @(negedge clk); load_i = 1'b0;
      chk(keys_o === 10'h2D3 && !busy_o, "R2 load", keys_o, 10'h2D3);

      // R3 exhaustive sweep, incl sorted, reverse and all-equal patterns
      for (int n = 0; n < (1 << BUS_W); n++) full_sort(BUS_W'(n), "R3 sort");

      // R5 phase order and unpaired end cell: cells 3,2,1,0,3
      v = '0;
      v[0*KEY_W +: KEY_W] = 2'd3; v[1*KEY_W +: KEY_W] = 2'd2; v[2*KEY_W +: KEY_W] = 2'd1;
      v[3*KEY_W +: KEY_W] = 2'd0; v[4*KEY_W +: KEY_W] = 2'd3;
      load_and_start(v);
      @(negedge clk);
      exp = ref_phase(v, 0);
      chk(keys_o === exp, "R5 after step 0", keys_o, exp);
      @(negedge clk);
      exp = ref_phase(exp, 1);
      chk(keys_o === exp, "R5 after step 1", keys_o, exp);
      repeat (CELLS) @(negedge clk);

      // R7 start while busy ignored
      a = 10'h0E4;
      load_and_start(a);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      for (int s = 1; s < CELLS; s++) @(negedge clk);
      chk(done_o === 1'b1, "R7 done not delayed", done_o, 1);
      chk(keys_o === ref_sort(a), "R7 keys", keys_o, ref_sort(a));
      @(negedge clk);
      chk(busy_o === 1'b0, "R7 no restart", busy_o, 0);

      // R6 load aborts run
      b = 10'h1B6;
      load_and_start(10'h3FC);
      @(negedge clk);
      load_i = 1'b1; load_keys_i = b;
      @(negedge clk); load_i = 1'b0;
      chk(keys_o === b && !busy_o, "R6 abort", keys_o, b);
      repeat (CELLS + 1) @(negedge clk);
      chk(keys_o === b && !done_o, "R6 idle after abort", keys_o, b);
      full_sort(b, "R6 resort");

      // R6 load and start together: load wins
      @(negedge clk); load_i = 1'b1; start_i = 1'b1; load_keys_i = 10'h0C9;
      @(negedge clk); load_i = 1'b0; start_i = 1'b0;
      chk(busy_o === 1'b0 && keys_o === 10'h0C9, "R6 load over start", {busy_o, keys_o}, 10'h0C9);
      repeat (CELLS + 1) @(negedge clk);
      chk(keys_o === 10'h0C9 && !done_o, "R8 idle stable", keys_o, 10'h0C9);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule